// File: doc/BRIEF.md
# Speculative Version Reconciliation Merger

This block builds the single program-order copy of one memory block whose speculative versions sit in up to sixteen caches. A reconcile starts when a flush request arrives from one cache. The block saves that cache's block data and per-word write mask in a holding buffer indexed by node identifier. In the next cycle it sends a fetch-and-invalidate multicast to every other speculative sharer, and it loads a down-counter with the number of answers it expects. Each reply is filed under its sender's identifier. When the counter reaches zero, each word is resolved on its own. The word is taken from the highest-numbered node whose mask marks it. Words that no node wrote keep the value currently held in memory. The merged block then goes out on a one-cycle write strobe.

A task that restarts after a squash needs a copy of the block built only from earlier tasks. The block serves this through a partial-merge request that names the task number. The answer is built from the buffered versions whose identifier is strictly below that number, and memory is not written.

Top module: `spec_version_merger`

## Requirements
- R1: After reset, `fetch_valid`, `mem_wr_en`, `done`, `part_valid` and `busy` are all low.
- R2: A flush request seen while idle is accepted. The requester's data and mask are stored at its identifier, and `busy` rises in the next cycle.
- R3: In the cycle after an accepted flush, `fetch_valid` pulses for one cycle. `fetch_targets` equals `flush_sharers` with the requester's bit cleared. When that set is empty, no fetch pulse is issued.
- R4: Each reply is stored at `reply_id`. The reply counter starts at the number of fetch targets. `mem_wr_en` stays low until the reply that brings the counter to zero has been taken.
- R5: Word w occupies bits [32w+31:32w] of a block and is governed by mask bit w. In the merged block, word w comes from the highest identifier whose stored mask bit w is set. When no stored mask has bit w set, word w is the matching word of `mem_rd_data`.
- R6: `mem_wr_en` and `done` pulse together for exactly one cycle. The pulse comes one cycle after the last reply was taken, or one cycle after the flush when there are no other sharers. All stored masks are cleared at the same time, so a later merge sees no writers.
- R7: A partial request for task t, made while not merging, raises `part_valid` in the next cycle. `part_data` is then merged only from stored versions with identifier below t, and t = 0 yields the memory value. No memory write occurs.
- R8: A flush request made while a reconcile is in progress is ignored. It stores nothing and issues no fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush_valid | input | 1 | Flush-for-reconcile request |
| flush_id | input | 4 | Requester identifier |
| flush_data | input | 512 | Requester's block data |
| flush_mask | input | 16 | Requester's per-word write mask |
| flush_sharers | input | 16 | Speculative sharer set of the block |
| reply_valid | input | 1 | Fetch-and-invalidate reply |
| reply_id | input | 4 | Replying node identifier |
| reply_data | input | 512 | Reply block data |
| reply_mask | input | 16 | Reply per-word write mask |
| partial_valid | input | 1 | Partial-merge request |
| partial_task | input | 5 | Task number t; versions below t are used |
| mem_rd_data | input | 512 | Current memory contents of the block |
| fetch_valid | output | 1 | Fetch-and-invalidate multicast strobe |
| fetch_targets | output | 16 | Nodes addressed by the multicast |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_wr_data | output | 512 | Merged block |
| done | output | 1 | Reconcile complete pulse |
| part_valid | output | 1 | Partial copy valid |
| part_data | output | 512 | Partially merged block |
| busy | output | 1 | Reconcile in progress |

## Verification
The sweeps aim at the priority order. Every round uses overlapping masks, so a design that picked the lowest writer, or the first reply to arrive, would write wrong words. Partial requests are swept over every task number from 0 to 16 while replies are still coming in. An off-by-one in the limit would let task t see its own version, and a missing arrival check would expose stale data left from an earlier round. Rounds with no other sharer and with all sixteen sharers probe the counter ends: a wrong load or a wrong zero test writes memory too early, too late, or never. A flush injected mid-reconcile, followed by a merge that must still match the model, catches a design that accepts requests while busy.

// File: rtl/recon_pkg.sv
package recon_pkg;
  localparam int unsigned DEF_NODES = 16;
  localparam int unsigned DEF_WORDS = 16;
  localparam int unsigned DEF_WORD_W = 32;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_COLLECT = 2'd1,
    ST_MERGE   = 2'd2
  } recon_state_e;
endpackage

// File: rtl/word_prio_pick.sv
module word_prio_pick #(
  parameter int unsigned N_NODES = recon_pkg::DEF_NODES,
  parameter int unsigned WORD_W  = recon_pkg::DEF_WORD_W,
  parameter int unsigned LIM_W   = $clog2(N_NODES) + 1
) (
  input  logic [N_NODES-1:0]             col_mask,
  input  logic [N_NODES-1:0][WORD_W-1:0] col_word,
  input  logic [LIM_W-1:0]               limit,
  input  logic [WORD_W-1:0]              fallback,
  output logic [WORD_W-1:0]              word_o
);
  // Ascending scan: the last eligible writer (highest id) wins.
  always_comb begin
    word_o = fallback;
    for (int j = 0; j < int'(N_NODES); j++) begin
      if (col_mask[j] && (LIM_W'(j) < limit)) begin
        word_o = col_word[j];
      end
    end
  end
endmodule

// File: rtl/version_merge.sv
module version_merge #(
  parameter int unsigned N_NODES = recon_pkg::DEF_NODES,
  parameter int unsigned N_WORDS = recon_pkg::DEF_WORDS,
  parameter int unsigned WORD_W  = recon_pkg::DEF_WORD_W,
  parameter int unsigned LIM_W   = $clog2(N_NODES) + 1,
  localparam int unsigned BLK_W  = N_WORDS * WORD_W
) (
  input  logic [N_NODES-1:0][BLK_W-1:0]   data_i,
  input  logic [N_NODES-1:0][N_WORDS-1:0] mask_i,
  input  logic [LIM_W-1:0]                limit,
  input  logic [BLK_W-1:0]                mem_i,
  output logic [BLK_W-1:0]                blk_o
);
  for (genvar w = 0; w < N_WORDS; w++) begin : g_word
    logic [N_NODES-1:0]             col_mask;
    logic [N_NODES-1:0][WORD_W-1:0] col_word;
    for (genvar j = 0; j < N_NODES; j++) begin : g_node
      assign col_mask[j] = mask_i[j][w];
      assign col_word[j] = data_i[j][w*WORD_W +: WORD_W];
    end
    word_prio_pick #(
      .N_NODES(N_NODES), .WORD_W(WORD_W), .LIM_W(LIM_W)
    ) i_pick (
      .col_mask (col_mask),
      .col_word (col_word),
      .limit    (limit),
      .fallback (mem_i[w*WORD_W +: WORD_W]),
      .word_o   (blk_o[w*WORD_W +: WORD_W])
    );
  end
endmodule

// File: rtl/version_store.sv
module version_store #(
  parameter int unsigned N_NODES = recon_pkg::DEF_NODES,
  parameter int unsigned N_WORDS = recon_pkg::DEF_WORDS,
  parameter int unsigned WORD_W  = recon_pkg::DEF_WORD_W,
  localparam int unsigned ID_W   = $clog2(N_NODES),
  localparam int unsigned BLK_W  = N_WORDS * WORD_W
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wr_en,
  input  logic [ID_W-1:0]                 wr_id,
  input  logic [BLK_W-1:0]                wr_data,
  input  logic [N_WORDS-1:0]              wr_mask,
  input  logic                            clr,
  output logic [N_NODES-1:0][BLK_W-1:0]   data_o,
  output logic [N_NODES-1:0][N_WORDS-1:0] mask_o,
  output logic                            mask_any
);
  logic [N_NODES-1:0][N_WORDS-1:0] mask_q, mask_d;

  always_comb begin
    mask_d = mask_q;
    if (clr) begin
      mask_d = '0;
    end else if (wr_en) begin
      mask_d[wr_id] = wr_mask;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '0;
    else        mask_q <= mask_d;
  end

  // Data needs no reset: masks gate every use of it.
  for (genvar j = 0; j < N_NODES; j++) begin : g_ent
    always_ff @(posedge clk) begin
      if (wr_en && !clr && (wr_id == ID_W'(j))) data_o[j] <= wr_data;
    end
  end

  assign mask_o   = mask_q;
  assign mask_any = |mask_q;

  a_r6_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !mask_any);
endmodule

// File: rtl/spec_version_merger.sv
module spec_version_merger #(
  parameter int unsigned N_NODES = recon_pkg::DEF_NODES,
  parameter int unsigned N_WORDS = recon_pkg::DEF_WORDS,
  parameter int unsigned WORD_W  = recon_pkg::DEF_WORD_W,
  localparam int unsigned ID_W   = $clog2(N_NODES),
  localparam int unsigned LIM_W  = ID_W + 1,
  localparam int unsigned CNT_W  = ID_W,
  localparam int unsigned BLK_W  = N_WORDS * WORD_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush_valid,
  input  logic [ID_W-1:0]    flush_id,
  input  logic [BLK_W-1:0]   flush_data,
  input  logic [N_WORDS-1:0] flush_mask,
  input  logic [N_NODES-1:0] flush_sharers,
  input  logic               reply_valid,
  input  logic [ID_W-1:0]    reply_id,
  input  logic [BLK_W-1:0]   reply_data,
  input  logic [N_WORDS-1:0] reply_mask,
  input  logic               partial_valid,
  input  logic [LIM_W-1:0]   partial_task,
  input  logic [BLK_W-1:0]   mem_rd_data,
  output logic               fetch_valid,
  output logic [N_NODES-1:0] fetch_targets,
  output logic               mem_wr_en,
  output logic [BLK_W-1:0]   mem_wr_data,
  output logic               done,
  output logic               part_valid,
  output logic [BLK_W-1:0]   part_data,
  output logic               busy
);
  import recon_pkg::*;

  recon_state_e state_q, state_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [N_NODES-1:0] others;
  logic               flush_take, reply_take, part_take, merging;
  logic               st_wr_en, mask_any;
  logic [ID_W-1:0]    st_wr_id;
  logic [BLK_W-1:0]   st_wr_data, full_blk, part_blk;
  logic [N_WORDS-1:0] st_wr_mask;
  logic [N_NODES-1:0][BLK_W-1:0]   buf_data;
  logic [N_NODES-1:0][N_WORDS-1:0] buf_mask;

  assign flush_take = flush_valid && (state_q == ST_IDLE);
  assign reply_take = reply_valid && (state_q == ST_COLLECT);
  assign merging    = (state_q == ST_MERGE);
  assign part_take  = partial_valid && !merging;
  assign others     = flush_sharers & ~(N_NODES'(1) << flush_id);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_IDLE: if (flush_take) begin
        cnt_d   = CNT_W'($countones(others));
        state_d = (others == '0) ? ST_MERGE : ST_COLLECT;
      end
      ST_COLLECT: if (reply_take) begin
        cnt_d = cnt_q - CNT_W'(1);
        if (cnt_q == CNT_W'(1)) state_d = ST_MERGE;
      end
      ST_MERGE: state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign st_wr_en   = flush_take || reply_take;
  assign st_wr_id   = flush_take ? flush_id   : reply_id;
  assign st_wr_data = flush_take ? flush_data : reply_data;
  assign st_wr_mask = flush_take ? flush_mask : reply_mask;

  version_store #(.N_NODES(N_NODES), .N_WORDS(N_WORDS), .WORD_W(WORD_W)) i_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (st_wr_en),
    .wr_id    (st_wr_id),
    .wr_data  (st_wr_data),
    .wr_mask  (st_wr_mask),
    .clr      (merging),
    .data_o   (buf_data),
    .mask_o   (buf_mask),
    .mask_any (mask_any)
  );

  version_merge #(.N_NODES(N_NODES), .N_WORDS(N_WORDS), .WORD_W(WORD_W), .LIM_W(LIM_W)) i_full (
    .data_i (buf_data),
    .mask_i (buf_mask),
    .limit  (LIM_W'(N_NODES)),
    .mem_i  (mem_rd_data),
    .blk_o  (full_blk)
  );

  version_merge #(.N_NODES(N_NODES), .N_WORDS(N_WORDS), .WORD_W(WORD_W), .LIM_W(LIM_W)) i_part (
    .data_i (buf_data),
    .mask_i (buf_mask),
    .limit  (partial_task),
    .mem_i  (mem_rd_data),
    .blk_o  (part_blk)
  );

  // Output strobes and their targets.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fetch_valid   <= 1'b0;
      fetch_targets <= '0;
      mem_wr_en     <= 1'b0;
      done          <= 1'b0;
      part_valid    <= 1'b0;
    end else begin
      fetch_valid   <= flush_take && (others != '0);
      fetch_targets <= flush_take ? others : '0;
      mem_wr_en     <= merging;
      done          <= merging;
      part_valid    <= part_take;
    end
  end

  // Wide data registers carry clock enables and no reset.
  always_ff @(posedge clk) begin
    if (merging)   mem_wr_data <= full_blk;
    if (part_take) part_data   <= part_blk;
  end

  assign busy = (state_q != ST_IDLE);

  a_r3_fetch_skips_requester: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid |-> !fetch_targets[$past(flush_id)]);
  a_r4_reply_only_collecting: assert property (@(posedge clk) disable iff (!rst_n)
    reply_valid |-> state_q == ST_COLLECT);
  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r6_masks_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !mask_any);
  a_r8_no_fetch_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_valid && busy) |=> !fetch_valid);
endmodule

// File: tb/test_spec_version_merger.sv
`timescale 1ns/1ps
module test_spec_version_merger;
  localparam int NN = 16;
  localparam int NW = 16;
  localparam int WW = 32;
  localparam int BW = NN * WW;

  logic clk = 1'b0;
  logic rst_n;
  logic flush_valid, reply_valid, partial_valid;
  logic [3:0] flush_id, reply_id;
  logic [BW-1:0] flush_data, reply_data, mem_rd_data;
  logic [NW-1:0] flush_mask, reply_mask;
  logic [NN-1:0] flush_sharers;
  logic [4:0] partial_task;
  logic fetch_valid, mem_wr_en, done, part_valid, busy;
  logic [NN-1:0] fetch_targets;
  logic [BW-1:0] mem_wr_data, part_data;

  int errors = 0;
  int checks = 0;
  logic [31:0] seed = 32'h1234_5678;

  logic [WW-1:0] m_data [NN][NW];
  logic [NW-1:0] m_mask [NN];
  bit            m_has  [NN];

  always #10 clk = ~clk;

  spec_version_merger i_spec_version_merger (.*);

  function automatic logic [31:0] nxt();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    return seed;
  endfunction

  function automatic logic [WW-1:0] mem_word(int w);
    return 32'hC0DE_0000 + w;
  endfunction

  function automatic logic [WW-1:0] exp_word(int w, int lim);
    logic [WW-1:0] r = mem_word(w);
    for (int j = 0; j < NN; j++)
      if (m_has[j] && m_mask[j][w] && j < lim) r = m_data[j][w];
    return r;
  endfunction

  function automatic logic [BW-1:0] pack(int j);
    logic [BW-1:0] b;
    for (int w = 0; w < NW; w++) b[w*WW +: WW] = m_data[j][w];
    return b;
  endfunction

  task automatic chk(bit ok, string req, logic [BW-1:0] act, logic [BW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_blk(string req, logic [BW-1:0] act, int lim);
    for (int w = 0; w < NW; w++)
      chk(act[w*WW +: WW] == exp_word(w, lim), req, act[w*WW +: WW], exp_word(w, lim));
  endtask

  task automatic partial(int t);
    partial_valid = 1'b1;
    partial_task  = 5'(t);
    @(negedge clk);
    partial_valid = 1'b0;
    chk(part_valid == 1'b1, "R7", part_valid, 1);
    chk(mem_wr_en == 1'b0, "R7", mem_wr_en, 0);
    chk_blk("R7", part_data, t);
  endtask

  // One complete reconcile; sweep_t >= 0 sweeps partial limits mid-collect.
  task automatic reconcile(int req, logic [NN-1:0] sh, bit sweep, bit inject);
    logic [NN-1:0] oth;
    int left;
    sh[req] = 1'b1;
    oth = sh & ~(NN'(1) << req);
    for (int j = 0; j < NN; j++) begin
      m_has[j] = 0;
      m_mask[j] = 16'(nxt()) & 16'(nxt());
      for (int w = 0; w < NW; w++) m_data[j][w] = nxt();
    end
    flush_valid = 1'b1; flush_id = 4'(req); flush_data = pack(req);
    flush_mask = m_mask[req]; flush_sharers = sh;
    @(negedge clk);
    flush_valid = 1'b0;
    m_has[req] = 1;
    chk(fetch_valid == (oth != 0), "R3", fetch_valid, oth != 0);
    chk(fetch_targets == oth, "R3", fetch_targets, oth);
    chk(busy == 1'b1, "R2", busy, 1);
    left = $countones(oth);
    for (int j = 0; j < NN; j++) begin
      if (!oth[j]) continue;
      if (inject) begin
        inject = 0;
        flush_valid = 1'b1; flush_id = 4'(j); flush_mask = '1;
        flush_data = ~pack(j); flush_sharers = '1;
        @(negedge clk);
        flush_valid = 1'b0;
        @(negedge clk);
        chk(fetch_valid == 1'b0, "R8", fetch_valid, 0);
        chk(mem_wr_en == 1'b0, "R8", mem_wr_en, 0);
      end
      reply_valid = 1'b1; reply_id = 4'(j);
      reply_data = pack(j); reply_mask = m_mask[j];
      @(negedge clk);
      reply_valid = 1'b0;
      m_has[j] = 1;
      left--;
      chk(mem_wr_en == 1'b0, "R4", mem_wr_en, 0);
      chk(fetch_valid == 1'b0, "R3", fetch_valid, 0);
      if (sweep && left == 1)
        for (int t = 0; t <= NN; t++) partial(t);
    end
    @(negedge clk);
    chk(mem_wr_en == 1'b1, "R6", mem_wr_en, 1);
    chk(done == 1'b1, "R6", done, 1);
    chk_blk("R5", mem_wr_data, NN);
    @(negedge clk);
    chk(done == 1'b0, "R6", done, 0);
    chk(mem_wr_en == 1'b0, "R6", mem_wr_en, 0);
    chk(busy == 1'b0, "R6", busy, 0);
    for (int j = 0; j < NN; j++) m_has[j] = 0;
    partial(NN);  // masks cleared: memory value expected (R6)
  endtask

  initial begin
    rst_n = 1'b0;
    flush_valid = 0; reply_valid = 0; partial_valid = 0;
    flush_id = 0; reply_id = 0; flush_data = '0; reply_data = '0;
    flush_mask = '0; reply_mask = '0; flush_sharers = '0; partial_task = '0;
    for (int w = 0; w < NW; w++) mem_rd_data[w*WW +: WW] = mem_word(w);
    repeat (3) @(negedge clk);
    chk(fetch_valid == 0 && mem_wr_en == 0 && done == 0 && part_valid == 0 && busy == 0,
        "R1", {fetch_valid, mem_wr_en, done, part_valid, busy}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0, "R1", busy, 0);
    reconcile(0, 16'h0001, 0, 0);      // lone sharer
    reconcile(3, 16'h8228, 1, 0);
    reconcile(15, 16'hFFFF, 1, 0);     // every node shares
    reconcile(7, 16'h0F0F, 0, 1);      // flush injected while busy
    for (int r = 0; r < 24; r++)
      reconcile(int'(nxt() % NN), 16'(nxt()), r % 4 == 0, r % 5 == 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule